// File: doc/BRIEF.md
# Standby Spare Selection Switch

This block picks which of N redundant modules drives a single output word in a standby redundancy arrangement. Each module supplies a data word, a fault line from its own detector and a heartbeat ("kick") line. A small watchdog per module turns a missing heartbeat into a fault. Routing follows a selection index. When a selected module is found faulty, the switch records it in a sticky faulty mask and moves to the next healthy module in a fixed ascending, wrapping order.

The parameter `PAIR_EN` chooses the variant. With it clear, one module is active. With it set, two modules are active together and their words are compared, so that a mismatch counts as a fault of the pair. When too few healthy modules remain to fill the selection, the block raises an exhausted flag and freezes the selection. Every switchover produces a one-cycle pulse.

Top module: `sps_switch`

## Requirements
- R1: `data_o` combinationally equals the data word of the primary selected module, `act_o`. Module k occupies bits `[k*DW +: DW]` of `data_i`.
- R2: A module's watchdog expires after `WDOG_CYC` consecutive clock edges without its kick bit high. An expired watchdog acts exactly as if that module's `fault_i` bit were high, and stays expired until the module is kicked again.
- R3: The `faulty_o` mask never loses a set bit. Only reset clears it.
- R4: If a selected module shows a fault in a cycle and the block is not exhausted, then at the next edge the faulty module is marked. The selection is then refilled with the first healthy indices found in ascending order, starting one above the last selected index and wrapping past N-1 to 0. `switch_o` is high for exactly the cycle that follows. A selected module is never marked faulty while the block is not exhausted.
- R5: If fewer healthy modules remain than the selection needs, the faulty units are still marked, `exhausted_o` rises and the selection holds. From then on, inputs change nothing except `data_o`, and `switch_o` stays low.
- R6: In pair mode, a data mismatch between the two selected modules with no detector fault marks both modules faulty.
- R7: In pair mode, a detector or watchdog fault on one selected module marks only that module. The refill still follows the order given in R4.
- R8: After reset the selection is indices 0 (primary) and 1 (secondary, pair mode only; simplex reports `act2_o` equal to `act_o`). `faulty_o` is 0, and `exhausted_o` and `switch_o` are low.
- R9: Faults on modules that are not selected are ignored. They change neither the mask nor the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | N*DW | Data words of all modules, module k at [k*DW +: DW] |
| fault_i | input | N | Per-module detector fault flags |
| kick_i | input | N | Per-module watchdog heartbeat |
| data_o | output | DW | Routed word of the primary selected module |
| act_o | output | IDX_W | Primary selected module index |
| act2_o | output | IDX_W | Secondary selected index (pair mode), else equals act_o |
| faulty_o | output | N | Sticky per-module faulty mask |
| exhausted_o | output | 1 | No healthy replacement available; selection frozen |
| switch_o | output | 1 | One-cycle pulse after each switchover |

## Verification
The assertions check the invariants that hold on every cycle. These are that the mask is sticky, that no selected unit is marked while healthy units remain, that every switch pulse marks at least one new module, that exhaustion freezes the selection, and that exhaustion implies enough marked modules. Only the bench's scenarios can show that the refill follows the exact wrap order, when the watchdog expires, that a pure mismatch marks both units while a detector fault marks just one, and that faults on idle modules are ignored. A behavioural model checks all of these cycle by cycle.

// File: rtl/sps_pkg.sv
package sps_pkg;
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sps_watchdog.sv
module sps_watchdog #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (kick_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/sps_route.sv
module sps_route #(
  parameter int N     = 4,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic [N*DW-1:0]  data_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic [DW-1:0]    data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < N; k++)
      if (sel_i == IDX_W'(k)) data_o = data_i[k*DW +: DW];
  end
endmodule

// File: rtl/sps_sequencer.sv
module sps_sequencer #(
  parameter int N     = 4,
  parameter int NSEL  = 1,
  parameter int IDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      fault_i,
  input  logic              mismatch_i,
  output logic [NSEL*IDX_W-1:0] sel_o,
  output logic [N-1:0]      faulty_o,
  output logic              exhausted_o,
  output logic              switch_o
);
  logic [IDX_W-1:0] sel_q [NSEL];
  logic [IDX_W-1:0] cand  [NSEL];
  logic [N-1:0]     faulty_q, hit, mark, mask_nx;
  logic             exh_q, sw_q, bad;
  int               found;

  always_comb begin
    hit = '0;
    for (int j = 0; j < NSEL; j++)
      if (fault_i[sel_q[j]]) hit[sel_q[j]] = 1'b1;
    bad  = (hit != '0) || mismatch_i;
    mark = hit;
    // pure mismatch cannot tell which unit is wrong: mark all selected
    if (hit == '0 && mismatch_i)
      for (int j = 0; j < NSEL; j++) mark[sel_q[j]] = 1'b1;
    mask_nx = faulty_q | mark;
    found   = 0;
    for (int j = 0; j < NSEL; j++) cand[j] = sel_q[j];
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(sel_q[NSEL-1]) + off) % N;
      if (!mask_nx[idx] && found < NSEL) begin
        cand[found] = IDX_W'(idx);
        found       = found + 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NSEL; j++) sel_q[j] <= IDX_W'(j);
      faulty_q <= '0;
      exh_q    <= 1'b0;
      sw_q     <= 1'b0;
    end else begin
      sw_q <= 1'b0;
      if (!exh_q && bad) begin
        faulty_q <= mask_nx;
        if (found >= NSEL) begin
          for (int j = 0; j < NSEL; j++) sel_q[j] <= cand[j];
          sw_q <= 1'b1;
        end else begin
          exh_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_o[g*IDX_W +: IDX_W] = sel_q[g];
  end

  assign faulty_o    = faulty_q;
  assign exhausted_o = exh_q;
  assign switch_o    = sw_q;
endmodule

// File: rtl/sps_switch.sv
module sps_switch
  import sps_pkg::*;
#(
  parameter int N        = 4,
  parameter int DW       = 8,
  parameter int WDOG_CYC = 16,
  parameter bit PAIR_EN  = 1'b0,
  localparam int IDX_W   = idx_width(N),
  localparam int NSEL    = PAIR_EN ? 2 : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N*DW-1:0]   data_i,
  input  logic [N-1:0]      fault_i,
  input  logic [N-1:0]      kick_i,
  output logic [DW-1:0]     data_o,
  output logic [IDX_W-1:0]  act_o,
  output logic [IDX_W-1:0]  act2_o,
  output logic [N-1:0]      faulty_o,
  output logic              exhausted_o,
  output logic              switch_o
);
  logic [N-1:0]          wd_exp, fault_eff;
  logic [NSEL*IDX_W-1:0] sel;
  logic                  mismatch;

  for (genvar k = 0; k < N; k++) begin : g_wd
    sps_watchdog #(.TIMEOUT(WDOG_CYC)) u_wd (
      .clk_i(clk_i), .rst_ni(rst_ni), .kick_i(kick_i[k]), .expired_o(wd_exp[k])
    );
  end

  assign fault_eff = fault_i | wd_exp;

  sps_sequencer #(.N(N), .NSEL(NSEL), .IDX_W(IDX_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_eff), .mismatch_i(mismatch),
    .sel_o(sel), .faulty_o(faulty_o), .exhausted_o(exhausted_o), .switch_o(switch_o)
  );

  assign act_o = sel[IDX_W-1:0];

  sps_route #(.N(N), .DW(DW), .IDX_W(IDX_W)) u_route0 (
    .data_i(data_i), .sel_i(act_o), .data_o(data_o)
  );

  if (PAIR_EN) begin : g_pair
    logic [DW-1:0] data_b;
    sps_route #(.N(N), .DW(DW), .IDX_W(IDX_W)) u_route1 (
      .data_i(data_i), .sel_i(sel[NSEL*IDX_W-1 -: IDX_W]), .data_o(data_b)
    );
    assign mismatch = (data_o != data_b);
    assign act2_o   = sel[NSEL*IDX_W-1 -: IDX_W];
  end else begin : g_single
    assign mismatch = 1'b0;
    assign act2_o   = act_o;
  end
endmodule

// File: rtl/sps_switch_chk.sv
module sps_switch_chk #(
  parameter int N     = 4,
  parameter int NSEL  = 1,
  parameter int IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] act_o,
  input logic [IDX_W-1:0] act2_o,
  input logic [N-1:0]     faulty_o,
  input logic             exhausted_o,
  input logic             switch_o
);
  AST_MASK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (faulty_o & $past(faulty_o)) == $past(faulty_o)); // R3

  AST_ACTIVE_HEALTHY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exhausted_o |-> (!faulty_o[act_o] && !faulty_o[act2_o])); // R4

  AST_SWITCH_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> ($countones(faulty_o) > $countones($past(faulty_o)))); // R4

  AST_EXHAUST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exhausted_o) |-> (exhausted_o && $stable(act_o) && $stable(act2_o) && !switch_o)); // R5

  AST_EXHAUST_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhausted_o |-> ($countones(faulty_o) > N - NSEL)); // R5
endmodule

bind sps_switch sps_switch_chk #(.N(N), .NSEL(NSEL), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_o(act_o), .act2_o(act2_o),
  .faulty_o(faulty_o), .exhausted_o(exhausted_o), .switch_o(switch_o)
);

// File: tb/sps_switch_tb.sv
module sps_switch_tb;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int WD = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N*DW-1:0] data_s, data_p;
  logic [N-1:0]    fault_s, fault_p, kick_s, kick_p;
  logic [DW-1:0]   d_s, d_p;
  logic [IW-1:0]   a_s, b_s, a_p, b_p;
  logic [N-1:0]    f_s, f_p;
  logic            e_s, e_p, w_s, w_p;

  sps_switch #(.N(N), .DW(DW), .WDOG_CYC(WD), .PAIR_EN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_s), .fault_i(fault_s), .kick_i(kick_s),
    .data_o(d_s), .act_o(a_s), .act2_o(b_s), .faulty_o(f_s), .exhausted_o(e_s), .switch_o(w_s));

  sps_switch #(.N(N), .DW(DW), .WDOG_CYC(WD), .PAIR_EN(1'b1)) u_pair (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_p), .fault_i(fault_p), .kick_i(kick_p),
    .data_o(d_p), .act_o(a_p), .act2_o(b_p), .faulty_o(f_p), .exhausted_o(e_p), .switch_o(w_p));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference, index 0 = simplex, 1 = pair
  int m_sel [2][2];
  int m_fault [2];
  bit m_exh [2];
  bit m_sw [2];
  int m_wd [2][N];

  task automatic check(string tag, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic model_rst();
    for (int m = 0; m < 2; m++) begin
      m_sel[m][0] = 0; m_sel[m][1] = 1;
      m_fault[m] = 0; m_exh[m] = 0; m_sw[m] = 0;
      for (int k = 0; k < N; k++) m_wd[m][k] = 0;
    end
  endtask

  task automatic model_step(int m, logic [N*DW-1:0] d, logic [N-1:0] flt, logic [N-1:0] kk);
    int nsel;
    int hit;
    int mark;
    int idx;
    bit mis;
    bit expd [N];
    int q [$];
    nsel = m + 1;
    hit  = 0;
    for (int k = 0; k < N; k++) expd[k] = (m_wd[m][k] == WD);
    for (int k = 0; k < N; k++)
      if (kk[k]) m_wd[m][k] = 0;
      else if (m_wd[m][k] < WD) m_wd[m][k]++;
    m_sw[m] = 0;
    if (!m_exh[m]) begin
      for (int j = 0; j < nsel; j++)
        if (flt[m_sel[m][j]] || expd[m_sel[m][j]]) hit |= (1 << m_sel[m][j]);
      mis = (m == 1) && (d[m_sel[m][0]*DW +: DW] != d[m_sel[m][1]*DW +: DW]);
      if (hit != 0 || mis) begin
        mark = hit;
        if (hit == 0)
          for (int j = 0; j < nsel; j++) mark |= (1 << m_sel[m][j]);
        m_fault[m] |= mark;
        for (int off = 1; off <= N; off++) begin
          idx = (m_sel[m][nsel-1] + off) % N;
          if (((m_fault[m] >> idx) & 1) == 0) q.push_back(idx);
        end
        if (q.size() >= nsel) begin
          for (int j = 0; j < nsel; j++) m_sel[m][j] = q[j];
          m_sw[m] = 1;
        end else begin
          m_exh[m] = 1;
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_rst();
    else begin
      model_step(0, data_s, fault_s, kick_s);
      model_step(1, data_p, fault_p, kick_p);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 simplex data_o", int'(d_s), int'(data_s[m_sel[0][0]*DW +: DW]));
      check("R4 simplex act_o", int'(a_s), m_sel[0][0]);
      check("R8 simplex act2_o", int'(b_s), m_sel[0][0]);
      check("R3 simplex faulty_o", int'(f_s), m_fault[0]);
      check("R5 simplex exhausted_o", int'(e_s), int'(m_exh[0]));
      check("R4 simplex switch_o", int'(w_s), int'(m_sw[0]));
      check("R1 pair data_o", int'(d_p), int'(data_p[m_sel[1][0]*DW +: DW]));
      check("R6 pair act_o", int'(a_p), m_sel[1][0]);
      check("R6 pair act2_o", int'(b_p), m_sel[1][1]);
      check("R7 pair faulty_o", int'(f_p), m_fault[1]);
      check("R5 pair exhausted_o", int'(e_p), int'(m_exh[1]));
      check("R4 pair switch_o", int'(w_p), int'(m_sw[1]));
    end
  end

  task automatic step_to_drive();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    data_s  = {8'h13, 8'h12, 8'h11, 8'h10};
    data_p  = {4{8'h5A}};
    fault_s = '0; fault_p = '0;
    kick_s  = '1; kick_p  = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 reset act_o", int'(a_s), 0);
    check("R8 reset faulty_o", int'(f_s), 0);
    check("R8 reset exhausted_o", int'(e_s), 0);
    check("R8 reset switch_o", int'(w_s), 0);
    check("R8 reset pair act2_o", int'(b_p), 1);
    check("R1 routes module 0", int'(d_s), 8'h10);

    // R9: fault on idle module 2
    step_to_drive(); fault_s = 4'b0100;
    step_to_drive(); fault_s = '0;
    @(negedge clk);
    check("R9 idle fault ignored faulty_o", int'(f_s), 0);
    check("R9 idle fault ignored act_o", int'(a_s), 0);

    // R4: fault on active module 0
    step_to_drive(); fault_s = 4'b0001;
    step_to_drive(); fault_s = '0;
    @(negedge clk);
    check("R4 switch to 1", int'(a_s), 1);
    check("R4 pulse", int'(w_s), 1);
    check("R4 mark 0", int'(f_s), 4'b0001);
    @(negedge clk);
    check("R4 pulse one cycle", int'(w_s), 0);

    // R2: starve module 1's watchdog
    step_to_drive(); kick_s = 4'b1101;
    repeat (WD - 1) step_to_drive();
    @(negedge clk);
    check("R2 no early expiry", int'(a_s), 1);
    repeat (4) step_to_drive();
    kick_s = '1;
    @(negedge clk);
    check("R2 watchdog switch to 2", int'(a_s), 2);
    check("R2 watchdog mark", int'(f_s), 4'b0011);
    check("R1 routes module 2", int'(d_s), 8'h12);

    // R4 then R5: exhaust the simplex switch
    step_to_drive(); fault_s = 4'b0100;
    step_to_drive(); fault_s = 4'b1000;
    step_to_drive(); fault_s = '0;
    @(negedge clk);
    check("R5 exhausted", int'(e_s), 1);
    check("R5 hold last", int'(a_s), 3);
    check("R5 all marked", int'(f_s), 4'b1111);
    check("R5 no pulse", int'(w_s), 0);
    step_to_drive(); fault_s = 4'b1000;
    step_to_drive(); fault_s = '0;
    @(negedge clk);
    check("R5 still held", int'(a_s), 3);

    // R7: single detector fault in pair mode
    step_to_drive(); fault_p = 4'b0001;
    step_to_drive(); fault_p = '0;
    @(negedge clk);
    check("R7 only flagged marked", int'(f_p), 4'b0001);
    check("R7 new primary", int'(a_p), 2);
    check("R7 new secondary", int'(b_p), 3);
    check("R7 pulse", int'(w_p), 1);

    // R6: mismatch between modules 2 and 3
    step_to_drive(); data_p[3*DW +: DW] = 8'h5B;
    step_to_drive(); data_p[3*DW +: DW] = 8'h5A;
    @(negedge clk);
    check("R6 both marked", int'(f_p), 4'b1101);
    check("R5 pair exhausted", int'(e_p), 1);
    check("R5 pair held primary", int'(a_p), 2);
    check("R5 pair held secondary", int'(b_p), 3);
    check("R1 pair data", int'(d_p), 8'h5A);

    repeat (5) step_to_drive();
    @(negedge clk);
    finish_run();
  end
endmodule